// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register-mapped front end of a flash memory controller. A bus master sets a clock divider, fills a small command parameter buffer through an index register, and writes a launch bit in a status register. The controller checks the launch against several conditions. The divider must have been written since reset. The bus clock must not be flagged as too slow. The command code must be one that is supported. No protection violation may be signalled. If a check fails, an error flag is set instead of starting the operation.

An accepted command clears the complete flag. The complete flag then stays low for a fixed number of divider ticks, which stand in for the array operation. When the period ends, the complete flag returns high and an interrupt pulse is issued. While a command is active, writes to the parameter buffer, the index and the divider are discarded. Error flags are cleared by writing 1 to them. A launch is refused while either error flag is set.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status register (address 1) reads 0x0080: the complete bit is 1 (bit 7), and the access-error bit (bit 5) and the protection-violation bit (bit 4) are 0. The divider register (address 0) reads 0x0000.
- R2: Writing the divider register (address 0) while idle stores bits 6:0 and sets the read-only loaded bit (bit 7). Reads return {loaded, value}.
- R3: A launch is a write to the status register with bit 7 set. A launch made before the divider has been written sets access-error and does not start a command.
- R4: A launch made while clk_slow_i is 1 sets access-error and does not start a command.
- R5: The command code is the upper byte of buffer word 0. Only codes 0x01 (program word), 0x02 (erase sector) and 0x03 (erase all) start a command. Any other code sets access-error.
- R6: A launch that passes all other checks while prot_viol_i is 1 sets protection-violation and does not start a command.
- R7: A launch is ignored while access-error or protection-violation is set, as sampled before the write. A write that both clears an error flag and sets the launch bit only clears the flag.
- R8: Writing 1 to status bit 5 or bit 4 clears that flag. Writing 0 leaves the flag unchanged.
- R9: After an accepted launch, the complete bit reads 0 for exactly BUSY_TICKS*(divider+1) clock cycles, and then reads 1 again.
- R10: irq_o is 1 for exactly one cycle: the first cycle in which the complete bit is back at 1 after a command.
- R11: While the complete bit is 0, writes to the index register (address 2), the data register (address 3) and the divider register are ignored.
- R12: The buffer holds 6 words of 16 bits. Address 3 reads and writes the word selected by the index register (address 2). An index write of 6 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the source of the divider tick |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| clk_slow_i | input | 1 | Bus clock is below the minimum for program and erase |
| prot_viol_i | input | 1 | The target of the command is protected |
| irq_o | output | 1 | Command-complete pulse |

## Verification
Two functions can act on the same status write: clearing an error flag by writing 1 to it, and the launch bit. The bench writes 0x0090 while protection-violation is set. It expects the flag to be cleared and no command to start, because the gate uses the flag value from before the write. A following plain launch must then run. A second overlap is a write that arrives while the command is active. The bench writes the index, a buffer word and the divider during the busy period, then reads all three back once the command has finished.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIV  = 3'd0,
    REG_STAT = 3'd1,
    REG_IDX  = 3'd2,
    REG_DATA = 3'd3
  } reg_addr_e;

  localparam int STAT_DONE = 7;
  localparam int STAT_ACC  = 5;
  localparam int STAT_PV   = 4;

  localparam logic [7:0] CMD_PROG_WORD = 8'h01;
  localparam logic [7:0] CMD_ERS_SECT  = 8'h02;
  localparam logic [7:0] CMD_ERS_ALL   = 8'h03;

  function automatic logic cmd_supported(input logic [7:0] code);
    return (code == CMD_PROG_WORD) || (code == CMD_ERS_SECT) || (code == CMD_ERS_ALL);
  endfunction
endpackage

// File: rtl/fcc_param_buf.sv
module fcc_param_buf #(
  parameter int WORDS = 6,
  parameter int W     = 16,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic [IW-1:0] idx_d_i,
  input  logic          data_we_i,
  input  logic [W-1:0]  data_d_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rdata_o,
  output logic [7:0]    cmd_o
);
  logic [IW-1:0] idx_q;
  logic [W-1:0]  mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      if (idx_we_i) idx_q <= idx_d_i;
      for (int i = 0; i < WORDS; i++)
        if (data_we_i && (int'(idx_q) == i)) mem_q[i] <= data_d_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < WORDS; i++)
      if (int'(idx_q) == i) rdata_o = mem_q[i];
  end

  assign idx_o = idx_q;
  assign cmd_o = mem_q[0][W-1 -: 8];

  // R12: the index never points past the last word
  a_r12_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < WORDS);
endmodule

// File: rtl/fcc_exec_timer.sv
module fcc_exec_timer #(
  parameter int DIV_W      = 7,
  parameter int BUSY_TICKS = 4,
  parameter int REM_W      = $clog2(BUSY_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             done_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e           state_q;
  logic [DIV_W-1:0] pre_q;
  logic [REM_W-1:0] rem_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          pre_q   <= '0;
          rem_q   <= REM_W'(BUSY_TICKS);
        end
        ST_RUN: begin
          if (pre_q == div_i) begin
            pre_q <= '0;
            // one time-base tick elapsed
            if (rem_q == REM_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              rem_q <= rem_q - 1'b1;
            end
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  // R9: a start only arrives while idle
  a_r9_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R10: completion follows a busy period
  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int BUSY_TICKS = 4,
  parameter int BUF_WORDS  = 6,
  parameter bit IRQ_EN     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              clk_slow_i,
  input  logic              prot_viol_i,
  output logic              irq_o
);
  localparam int IW = $clog2(BUF_WORDS);

  logic [DIV_W-1:0]  div_q;
  logic              div_ld_q, acc_q, pv_q;
  logic              busy, done, done_flag;
  logic              we_div, we_stat, we_idx, we_data;
  logic              launch, acc_cause, start;
  logic [IW-1:0]     buf_idx;
  logic [DATA_W-1:0] buf_rdata;
  logic [7:0]        cmd_code;

  assign done_flag = !busy;
  assign we_div  = reg_we_i && (reg_addr_i == REG_DIV)  && !busy;
  assign we_stat = reg_we_i && (reg_addr_i == REG_STAT);
  assign we_idx  = reg_we_i && (reg_addr_i == REG_IDX)  && !busy
                   && (reg_wdata_i < DATA_W'(BUF_WORDS));
  assign we_data = reg_we_i && (reg_addr_i == REG_DATA) && !busy;

  // gate uses flag values from before this write
  assign launch    = we_stat && reg_wdata_i[STAT_DONE] && !busy && !acc_q && !pv_q;
  assign acc_cause = !div_ld_q || clk_slow_i || !cmd_supported(cmd_code);
  assign start     = launch && !acc_cause && !prot_viol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      div_ld_q <= 1'b0;
      acc_q    <= 1'b0;
      pv_q     <= 1'b0;
    end else begin
      if (we_div) begin
        div_q    <= reg_wdata_i[DIV_W-1:0];
        div_ld_q <= 1'b1;
      end
      if (launch && acc_cause)                      acc_q <= 1'b1;
      else if (we_stat && reg_wdata_i[STAT_ACC])    acc_q <= 1'b0;
      if (launch && !acc_cause && prot_viol_i)      pv_q  <= 1'b1;
      else if (we_stat && reg_wdata_i[STAT_PV])     pv_q  <= 1'b0;
    end
  end

  fcc_param_buf #(.WORDS(BUF_WORDS), .W(DATA_W), .IW(IW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_we_i  (we_idx),
    .idx_d_i   (reg_wdata_i[IW-1:0]),
    .data_we_i (we_data),
    .data_d_i  (reg_wdata_i),
    .idx_o     (buf_idx),
    .rdata_o   (buf_rdata),
    .cmd_o     (cmd_code)
  );

  fcc_exec_timer #(.DIV_W(DIV_W), .BUSY_TICKS(BUSY_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .div_i   (div_q),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_DIV: begin
        reg_rdata_o[DIV_W-1:0] = div_q;
        reg_rdata_o[7]         = div_ld_q;
      end
      REG_STAT: begin
        reg_rdata_o[STAT_DONE] = done_flag;
        reg_rdata_o[STAT_ACC]  = acc_q;
        reg_rdata_o[STAT_PV]   = pv_q;
      end
      REG_IDX:  reg_rdata_o = DATA_W'(buf_idx);
      REG_DATA: reg_rdata_o = buf_rdata;
      default:  reg_rdata_o = '0;
    endcase
  end

  generate
    if (IRQ_EN) begin : g_irq
      assign irq_o = done;
    end else begin : g_no_irq
      assign irq_o = 1'b0;
    end
  endgenerate

  // R3: a command only starts once the divider is loaded
  a_r3_start_needs_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag) |-> $past(div_ld_q));
  // R4: slow clock blocks execution
  a_r4_slow_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag) |-> !$past(clk_slow_i));
  // R7: no start with an error flag pending
  a_r7_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag) |-> (!$past(acc_q) && !$past(pv_q)));
  // R6: protection violation blocks execution
  a_r6_prot_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag) |-> !$past(prot_viol_i));
  // R11: buffer state frozen across a write while busy
  a_r11_buf_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && busy && (reg_addr_i == REG_IDX || reg_addr_i == REG_DATA))
      |=> ($stable(buf_idx) && $stable(buf_rdata)));
  // R10: single-cycle interrupt, only when idle
  a_r10_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r10_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_flag);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int T = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        slow = 1'b0;
  logic        pviol = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.DIV_W(7), .BUSY_TICKS(T), .BUF_WORDS(6), .IRQ_EN(1'b1)) u_flash_cmd_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .clk_slow_i  (slow),
    .prot_viol_i (pviol),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // waits for completion at negedges, returns busy cycles and irq seen at the rise
  task automatic wait_done(output int n, output logic irq_at_rise, output logic irq_after);
    logic [15:0] s;
    n = 0;
    rd(3'd1, s);
    while (s[7] == 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
      rd(3'd1, s);
    end
    irq_at_rise = irq;
    @(negedge clk);
    irq_after = irq;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    logic ia, ib;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd1, v); check("R1 stat", v, 16'h0080);
    rd(3'd0, v); check("R1 div", v, 16'h0000);

    // R3 launch before divider loaded
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h0100);
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R3 no div", v, 16'h00A0);

    // R8 write 0 keeps flag, write 1 clears
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R8 zero keeps", v, 16'h00A0);
    wr(3'd1, 16'h0020);
    rd(3'd1, v); check("R8 clear acc", v, 16'h0080);

    // R2 divider load
    wr(3'd0, 16'h0005);
    rd(3'd0, v); check("R2 div", v, 16'h0085);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R2 div zero", v, 16'h0080);

    // R4 slow clock
    slow = 1'b1;
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R4 slow", v, 16'h00A0);
    slow = 1'b0;
    // R7 launch ignored with access-error set, even with valid conditions
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R7 acc gate", v, 16'h00A0);
    wr(3'd1, 16'h0020);

    // R6 protection violation
    pviol = 1'b1;
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R6 pviol", v, 16'h0090);
    pviol = 1'b0;
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R7 pv gate", v, 16'h0090);
    // R7 clear and launch in one write: only clears
    wr(3'd1, 16'h0090);
    rd(3'd1, v); check("R7 same write", v, 16'h0080);
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R7 then runs", v, 16'h0000);
    wait_done(n, ia, ib);

    // R5 sweep of every command code, divider 0
    for (int c = 0; c < 256; c++) begin
      bit ok;
      ok = (c >= 1 && c <= 3);
      wr(3'd2, 16'd0);
      wr(3'd3, 16'(c << 8));
      wr(3'd1, 16'h0080);
      rd(3'd1, v);
      check($sformatf("R5 code %0h", c), v, ok ? 16'h0000 : 16'h00A0);
      if (ok) begin
        wait_done(n, ia, ib);
        check("R9 div0 busy", 16'(n), 16'(T));
      end else begin
        wr(3'd1, 16'h0020);
      end
    end

    // R9 / R10 sweep of divider values
    wr(3'd3, 16'h0200);
    for (int d = 0; d < 8; d++) begin
      wr(3'd0, 16'(d));
      wr(3'd1, 16'h0080);
      wait_done(n, ia, ib);
      check($sformatf("R9 busy div %0d", d), 16'(n), 16'(T * (d + 1)));
      check("R10 irq at completion", {15'd0, ia}, 16'd1);
      check("R10 irq one cycle", {15'd0, ib}, 16'd0);
    end

    // R11 writes during busy ignored
    wr(3'd0, 16'd7);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'h1234);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'h0080);
    rd(3'd1, v); check("R11 busy", v, 16'h0000);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'hBEEF);
    wr(3'd0, 16'd2);
    wait_done(n, ia, ib);
    rd(3'd2, v); check("R11 idx kept", v, 16'd0);
    rd(3'd3, v); check("R11 word0 kept", v, 16'h0200);
    rd(3'd0, v); check("R11 div kept", v, 16'h0087);
    wr(3'd2, 16'd1);
    rd(3'd3, v); check("R11 word1 kept", v, 16'h1234);

    // R12 buffer indexing
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, 16'(i));
      wr(3'd3, 16'(16'hA000 + i * 16'h0111));
    end
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, 16'(i));
      rd(3'd3, v); check($sformatf("R12 word %0d", i), v, 16'(16'hA000 + i * 16'h0111));
    end
    wr(3'd2, 16'd6);
    rd(3'd2, v); check("R12 idx 6 ignored", v, 16'd5);
    wr(3'd2, 16'd8);
    rd(3'd2, v); check("R12 idx 8 ignored", v, 16'd5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule